// File: doc/BRIEF.md
# Issue Stage Operand Lookup

This block sits at the issue point of an out-of-order core and handles one decoded instruction per cycle. It holds a producer table: for every architectural register, a pending flag and the reorder-buffer tag of the youngest instruction in flight that will write it. Each of the two source operands is resolved in the same cycle. A register with no pending writer is read from the register file. Otherwise the value is taken from the result bus if the producer is broadcasting in that cycle, or from the reorder buffer if that entry has already completed. If none of these supplies it, the producer tag goes to the reservation station in place of the value, and the station waits for that tag on the result bus.

When the target function unit has a free reservation station and the reorder buffer has space, the instruction is accepted in that cycle. The block writes the station for that unit and allocates the reorder-buffer entry at its tail pointer. For an instruction that writes a register, it records the destination address in that entry and the entry's tag in the producer table. Commits from the buffer head release producer-table entries that still name the committing tag. A flush empties the table and rewinds the allocation state. The reservation stations, the register file and the buffer storage are outside the block and are reached only through its read and write ports.

Top module: `issue_lookup`

## Requirements
- R1: After reset the producer table is empty, so every operand is ready with its register-file value, and the first allocation uses reorder-buffer tag 0.
- R2: `issue_fire` is high exactly when `in_valid` is high, `rs_free[in_fu]` is high, the reorder buffer is not full and `flush` is low. In that cycle `rob_we` is high and `rs_we` has only bit `in_fu` set. Otherwise `rob_we` is low and `rs_we` is all zero.
- R3: An operand whose register has no pending writer is given with ready=1, value equal to the register-file read data for that register, and tag 0.
- R4: An operand whose register is pending, while `cdb_valid` is high with `cdb_tag` equal to the producer tag, is given with ready=1, the value `cdb_data` and tag 0.
- R5: An operand whose register is pending, with no matching result-bus broadcast and the reorder buffer reporting that tag complete, is given with ready=1, the reorder-buffer data and tag 0.
- R6: An operand whose register is pending with neither source available is given with ready=0, value 0 and tag equal to the producer tag.
- R7: When an instruction with a destination is accepted, the new entry receives the destination address, and from the next cycle that register is pending with the allocated tag. Sources of that same instruction still use the mapping from before the instruction.
- R8: `rob_wr_tag` and `rs_rob_tag` carry the tail pointer, which advances by one, modulo the buffer depth, on each accepted instruction.
- R9: A commit of tag T clears every pending register whose recorded tag is T, except a register that an accepted instruction writes in the same cycle.
- R10: Occupancy rises by one per accepted instruction and falls by one per commit. While it equals the buffer depth, no instruction is accepted.
- R11: `flush` clears every pending flag, sets the tail pointer and the occupancy to zero, and blocks acceptance in that cycle.
- R12: An accepted instruction with `in_has_dst` low leaves the producer table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear producer table and allocation state |
| in_valid | input | 1 | Decoded instruction present |
| in_fu | input | FUW | Target function unit index |
| in_op | input | OPW | Operation code passed to the station |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| issue_fire | output | 1 | Instruction accepted this cycle |
| rs_free | input | NFU | One free-station flag per function unit |
| rf_addr_a | output | RW | Register-file read address, first source |
| rf_addr_b | output | RW | Register-file read address, second source |
| rf_data_a | input | DW | Register-file read data, first source |
| rf_data_b | input | DW | Register-file read data, second source |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAGW | Result bus producer tag |
| cdb_data | input | DW | Result bus value |
| rob_rd_tag_a | output | TAGW | Reorder-buffer read tag, first source |
| rob_rd_tag_b | output | TAGW | Reorder-buffer read tag, second source |
| rob_rd_done_a | input | 1 | Entry for first source has completed |
| rob_rd_done_b | input | 1 | Entry for second source has completed |
| rob_rd_data_a | input | DW | Completed result, first source |
| rob_rd_data_b | input | DW | Completed result, second source |
| commit_valid | input | 1 | Head entry commits this cycle |
| commit_tag | input | TAGW | Tag of committing entry |
| rob_we | output | 1 | Allocate reorder-buffer entry |
| rob_wr_tag | output | TAGW | Entry being allocated |
| rob_wr_has_dst | output | 1 | Allocated entry writes a register |
| rob_wr_dst | output | RW | Destination stored in the entry |
| rs_we | output | NFU | Reservation-station write, one per unit |
| rs_op | output | OPW | Operation code for the station |
| rs_rob_tag | output | TAGW | Own reorder-buffer tag for the station |
| rs_a_rdy | output | 1 | First operand value valid |
| rs_a_val | output | DW | First operand value |
| rs_a_tag | output | TAGW | First operand producer tag when not ready |
| rs_b_rdy | output | 1 | Second operand value valid |
| rs_b_val | output | DW | Second operand value |
| rs_b_tag | output | TAGW | Second operand producer tag when not ready |

## Verification
The bench builds the block with a four-entry reorder buffer, two function units, 8-bit data and the full 16 registers. With only four tags the buffer fills and wraps within a few instructions, so the full stall, tail wraparound and tag reuse after commit happen thousands of times. Tags are reused quickly enough that a stale producer entry would collide with a fresh allocation. Sources are biased toward a few registers, so same-cycle bus hits, completed-entry reads, writes to a register that is read in the same cycle, and commit-versus-rewrite races all occur often next to plain register-file reads. Periodic flushes bring the rewind to zero into the same sweep.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_BUS = 2'd1,
    SRC_ROB = 2'd2,
    SRC_TAG = 2'd3
  } src_e;

  // Pointer advance with wrap at an arbitrary depth.
  function automatic int wrap_inc(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Operand source choice, given the lookup conditions.
  function automatic src_e pick_src(input logic pend, input logic bus_hit,
                                    input logic rob_done);
    if (!pend)         return SRC_RF;
    else if (bus_hit)  return SRC_BUS;
    else if (rob_done) return SRC_ROB;
    else               return SRC_TAG;
  endfunction

endpackage

// File: rtl/prod_table.sv
module prod_table #(
  parameter int NREG = 16,
  parameter int TAGW = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_reg,
  input  logic [TAGW-1:0] wr_tag,
  input  logic            clr_en,
  input  logic [TAGW-1:0] clr_tag,
  input  logic [RW-1:0]   rd_reg_a,
  input  logic [RW-1:0]   rd_reg_b,
  output logic            pend_a,
  output logic [TAGW-1:0] tag_a,
  output logic            pend_b,
  output logic [TAGW-1:0] tag_b
);

  logic [NREG-1:0]           pend_q;
  logic [NREG-1:0][TAGW-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tag_q  <= '0;
    end else if (flush) begin
      pend_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en && wr_reg == RW'(r)) begin
          pend_q[r] <= 1'b1;
          tag_q[r]  <= wr_tag;
        end else if (clr_en && pend_q[r] && tag_q[r] == clr_tag) begin
          pend_q[r] <= 1'b0;
        end
      end
    end
  end

  assign pend_a = pend_q[rd_reg_a];
  assign tag_a  = tag_q[rd_reg_a];
  assign pend_b = pend_q[rd_reg_b];
  assign tag_b  = tag_q[rd_reg_b];

  // Named events for the checks below.
  logic clr_hit_a;
  assign clr_hit_a = clr_en && !flush && pend_a && tag_a == clr_tag &&
                     !(wr_en && wr_reg == rd_reg_a);

  a_r7_record_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (pend_q[$past(wr_reg)] && tag_q[$past(wr_reg)] == $past(wr_tag)));

  a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit_a |=> !pend_q[$past(rd_reg_a)]);

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_q == '0));

  a_r12_table_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en && !flush) |=> ($stable(pend_q) && $stable(tag_q)));

endmodule

// File: rtl/operand_pick.sv
module operand_pick #(
  parameter int DW   = 64,
  parameter int TAGW = 4
) (
  input  logic             pend,
  input  logic [TAGW-1:0]  ptag,
  input  logic [DW-1:0]    rf_data,
  input  logic             bus_valid,
  input  logic [TAGW-1:0]  bus_tag,
  input  logic [DW-1:0]    bus_data,
  input  logic             rob_done,
  input  logic [DW-1:0]    rob_data,
  output logic             rdy,
  output logic [DW-1:0]    val,
  output logic [TAGW-1:0]  tag,
  output issue_pkg::src_e  src
);

  logic bus_hit;
  assign bus_hit = bus_valid && bus_tag == ptag;
  assign src     = issue_pkg::pick_src(pend, bus_hit, rob_done);

  always_comb begin
    rdy = 1'b1;
    val = '0;
    tag = '0;
    unique case (src)
      issue_pkg::SRC_RF:  val = rf_data;
      issue_pkg::SRC_BUS: val = bus_data;
      issue_pkg::SRC_ROB: val = rob_data;
      issue_pkg::SRC_TAG: begin
        rdy = 1'b0;
        tag = ptag;
      end
      default: rdy = 1'b0;
    endcase
  end

endmodule

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH = 16,
  localparam int TAGW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc,
  input  logic            commit,
  output logic [TAGW-1:0] tail,
  output logic            full
);

  logic [TAGW-1:0] tail_q;
  logic [CW-1:0]   count_q;
  logic            do_commit;

  assign do_commit = commit && count_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc)
        tail_q <= TAGW'(issue_pkg::wrap_inc(int'(tail_q), DEPTH));
      case ({alloc, do_commit})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign tail = tail_q;
  assign full = count_q == CW'(DEPTH);

  a_r8_tail_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !flush) |=> (tail_q == TAGW'(issue_pkg::wrap_inc(int'($past(tail_q)), DEPTH))));

  a_r10_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);

  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  a_r11_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail_q == '0 && count_q == '0));

endmodule

// File: rtl/fu_select.sv
module fu_select #(
  parameter int NFU = 4,
  localparam int FUW = $clog2(NFU)
) (
  input  logic [FUW-1:0] fu,
  input  logic [NFU-1:0] free,
  input  logic           go,
  output logic           sel_free,
  output logic [NFU-1:0] we
);

  assign sel_free = free[fu];

  for (genvar i = 0; i < NFU; i++) begin : g_we
    assign we[i] = go && fu == FUW'(i);
  end

endmodule

// File: rtl/issue_lookup.sv
module issue_lookup #(
  parameter int NREG  = 16,
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  parameter int NFU   = 4,
  parameter int OPW   = 8,
  localparam int RW   = $clog2(NREG),
  localparam int TAGW = $clog2(DEPTH),
  localparam int FUW  = $clog2(NFU)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  input  logic [FUW-1:0]  in_fu,
  input  logic [OPW-1:0]  in_op,
  input  logic            in_has_dst,
  input  logic [RW-1:0]   in_dst,
  input  logic [RW-1:0]   in_src_a,
  input  logic [RW-1:0]   in_src_b,
  output logic            issue_fire,
  input  logic [NFU-1:0]  rs_free,
  output logic [RW-1:0]   rf_addr_a,
  output logic [RW-1:0]   rf_addr_b,
  input  logic [DW-1:0]   rf_data_a,
  input  logic [DW-1:0]   rf_data_b,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_data,
  output logic [TAGW-1:0] rob_rd_tag_a,
  output logic [TAGW-1:0] rob_rd_tag_b,
  input  logic            rob_rd_done_a,
  input  logic            rob_rd_done_b,
  input  logic [DW-1:0]   rob_rd_data_a,
  input  logic [DW-1:0]   rob_rd_data_b,
  input  logic            commit_valid,
  input  logic [TAGW-1:0] commit_tag,
  output logic            rob_we,
  output logic [TAGW-1:0] rob_wr_tag,
  output logic            rob_wr_has_dst,
  output logic [RW-1:0]   rob_wr_dst,
  output logic [NFU-1:0]  rs_we,
  output logic [OPW-1:0]  rs_op,
  output logic [TAGW-1:0] rs_rob_tag,
  output logic            rs_a_rdy,
  output logic [DW-1:0]   rs_a_val,
  output logic [TAGW-1:0] rs_a_tag,
  output logic            rs_b_rdy,
  output logic [DW-1:0]   rs_b_val,
  output logic [TAGW-1:0] rs_b_tag
);

  // Internal events, named for the checks.
  logic            rob_full;
  logic            unit_free;
  logic [TAGW-1:0] tail;
  logic            tbl_wr;
  logic            pend_a, pend_b;
  logic [TAGW-1:0] ptag_a, ptag_b;

  assign issue_fire = in_valid && unit_free && !rob_full && !flush;
  assign tbl_wr     = issue_fire && in_has_dst;

  fu_select #(.NFU(NFU)) u_sel (
    .fu       (in_fu),
    .free     (rs_free),
    .go       (issue_fire),
    .sel_free (unit_free),
    .we       (rs_we)
  );

  rob_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .alloc  (issue_fire),
    .commit (commit_valid),
    .tail   (tail),
    .full   (rob_full)
  );

  prod_table #(.NREG(NREG), .TAGW(TAGW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (tbl_wr),
    .wr_reg   (in_dst),
    .wr_tag   (tail),
    .clr_en   (commit_valid),
    .clr_tag  (commit_tag),
    .rd_reg_a (in_src_a),
    .rd_reg_b (in_src_b),
    .pend_a   (pend_a),
    .tag_a    (ptag_a),
    .pend_b   (pend_b),
    .tag_b    (ptag_b)
  );

  // Per-operand lookup, index 0 = first source, 1 = second.
  logic [1:0]            op_pend;
  logic [1:0][TAGW-1:0]  op_ptag;
  logic [1:0][DW-1:0]    op_rf;
  logic [1:0]            op_done;
  logic [1:0][DW-1:0]    op_robd;
  logic [1:0]            op_rdy;
  logic [1:0][DW-1:0]    op_val;
  logic [1:0][TAGW-1:0]  op_tag;
  issue_pkg::src_e       op_src [2];

  assign op_pend = {pend_b, pend_a};
  assign op_ptag = {ptag_b, ptag_a};
  assign op_rf   = {rf_data_b, rf_data_a};
  assign op_done = {rob_rd_done_b, rob_rd_done_a};
  assign op_robd = {rob_rd_data_b, rob_rd_data_a};

  for (genvar k = 0; k < 2; k++) begin : g_op
    operand_pick #(.DW(DW), .TAGW(TAGW)) u_pick (
      .pend      (op_pend[k]),
      .ptag      (op_ptag[k]),
      .rf_data   (op_rf[k]),
      .bus_valid (cdb_valid),
      .bus_tag   (cdb_tag),
      .bus_data  (cdb_data),
      .rob_done  (op_done[k]),
      .rob_data  (op_robd[k]),
      .rdy       (op_rdy[k]),
      .val       (op_val[k]),
      .tag       (op_tag[k]),
      .src       (op_src[k])
    );
  end

  assign rf_addr_a    = in_src_a;
  assign rf_addr_b    = in_src_b;
  assign rob_rd_tag_a = ptag_a;
  assign rob_rd_tag_b = ptag_b;

  assign rob_we         = issue_fire;
  assign rob_wr_tag     = tail;
  assign rob_wr_has_dst = in_has_dst;
  assign rob_wr_dst     = in_dst;

  assign rs_op      = in_op;
  assign rs_rob_tag = tail;
  assign rs_a_rdy   = op_rdy[0];
  assign rs_a_val   = op_val[0];
  assign rs_a_tag   = op_tag[0];
  assign rs_b_rdy   = op_rdy[1];
  assign rs_b_val   = op_val[1];
  assign rs_b_tag   = op_tag[1];

  a_r2_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rs_we) && ((rs_we != '0) == rob_we));

  a_r2_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    rob_we |-> (in_valid && rs_free[in_fu] && !flush));

  a_r3_rf_source: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_a |-> (rs_a_rdy && rs_a_val == rf_data_a && op_src[0] == issue_pkg::SRC_RF));

  a_r4_bus_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && cdb_valid && cdb_tag == ptag_a) |-> (rs_a_rdy && rs_a_val == cdb_data));

  a_r5_rob_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_b && !(cdb_valid && cdb_tag == ptag_b) && rob_rd_done_b) |->
      (rs_b_rdy && rs_b_val == rob_rd_data_b));

  a_r6_tag_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && !(cdb_valid && cdb_tag == ptag_a) && !rob_rd_done_a) |->
      (!rs_a_rdy && rs_a_tag == ptag_a));

endmodule

// File: tb/sim_issue_lookup.sv
module sim_issue_lookup;

  localparam int NREG = 16, DW = 8, DEPTH = 4, NFU = 2, OPW = 4;
  localparam int RW = 4, TAGW = 2, FUW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic flush, in_valid, in_has_dst, cdb_valid, commit_valid;
  logic [FUW-1:0] in_fu;
  logic [OPW-1:0] in_op;
  logic [RW-1:0] in_dst, in_src_a, in_src_b;
  logic [NFU-1:0] rs_free;
  logic [TAGW-1:0] cdb_tag, commit_tag;
  logic [DW-1:0] cdb_data;

  logic issue_fire, rob_we, rob_wr_has_dst, rs_a_rdy, rs_b_rdy;
  logic [RW-1:0] rf_addr_a, rf_addr_b, rob_wr_dst;
  logic [DW-1:0] rf_data_a, rf_data_b, rob_rd_data_a, rob_rd_data_b, rs_a_val, rs_b_val;
  logic [TAGW-1:0] rob_rd_tag_a, rob_rd_tag_b, rob_wr_tag, rs_rob_tag, rs_a_tag, rs_b_tag;
  logic rob_rd_done_a, rob_rd_done_b;
  logic [NFU-1:0] rs_we;
  logic [OPW-1:0] rs_op;

  // Bench-side reorder-buffer storage and model state.
  logic [DEPTH-1:0] rdone;
  logic [DW-1:0]    rdata [DEPTH];
  logic             m_pend [NREG];
  logic [TAGW-1:0]  m_tag  [NREG];
  int m_tail, m_count, m_head;
  int errors = 0, checks = 0;

  function automatic logic [DW-1:0] rfv(input logic [RW-1:0] r);
    return {~r, r};
  endfunction

  assign rf_data_a     = rfv(rf_addr_a);
  assign rf_data_b     = rfv(rf_addr_b);
  assign rob_rd_done_a = rdone[rob_rd_tag_a];
  assign rob_rd_done_b = rdone[rob_rd_tag_b];
  assign rob_rd_data_a = rdata[rob_rd_tag_a];
  assign rob_rd_data_b = rdata[rob_rd_tag_b];

  issue_lookup #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .NFU(NFU), .OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_fu(in_fu),
    .in_op(in_op), .in_has_dst(in_has_dst), .in_dst(in_dst), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .issue_fire(issue_fire), .rs_free(rs_free),
    .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b), .rf_data_a(rf_data_a),
    .rf_data_b(rf_data_b), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .rob_rd_tag_a(rob_rd_tag_a), .rob_rd_tag_b(rob_rd_tag_b),
    .rob_rd_done_a(rob_rd_done_a), .rob_rd_done_b(rob_rd_done_b),
    .rob_rd_data_a(rob_rd_data_a), .rob_rd_data_b(rob_rd_data_b),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .rob_we(rob_we),
    .rob_wr_tag(rob_wr_tag), .rob_wr_has_dst(rob_wr_has_dst), .rob_wr_dst(rob_wr_dst),
    .rs_we(rs_we), .rs_op(rs_op), .rs_rob_tag(rs_rob_tag), .rs_a_rdy(rs_a_rdy),
    .rs_a_val(rs_a_val), .rs_a_tag(rs_a_tag), .rs_b_rdy(rs_b_rdy),
    .rs_b_val(rs_b_val), .rs_b_tag(rs_b_tag)
  );

  task automatic chk(input string req, input string ctx, input string what,
                     input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] %s: got %0h exp %0h", req, ctx, what, got, exp);
    end
  endtask

  // Expected operand from the bench model (R3..R6).
  task automatic exp_op(input logic [RW-1:0] r, output logic rdy,
                        output logic [DW-1:0] val, output logic [TAGW-1:0] tag,
                        output string req);
    rdy = 1'b1; val = '0; tag = '0;
    if (!m_pend[r]) begin
      req = "R3"; val = rfv(r);
    end else if (cdb_valid && cdb_tag == m_tag[r]) begin
      req = "R4"; val = cdb_data;
    end else if (rdone[m_tag[r]]) begin
      req = "R5"; val = rdata[m_tag[r]];
    end else begin
      req = "R6"; rdy = 1'b0; tag = m_tag[r];
    end
  endtask

  task automatic clear_model();
    for (int r = 0; r < NREG; r++) begin
      m_pend[r] = 1'b0;
      m_tag[r] = '0;
    end
    m_tail = 0; m_count = 0; m_head = 0; rdone = '0;
  endtask

  // Check outputs mid-cycle, then advance the model across the edge.
  task automatic step(input string ctx);
    logic efire, ar, br;
    logic [DW-1:0] av, bv;
    logic [TAGW-1:0] at, bt;
    string aq, bq;
    #1;
    efire = in_valid && rs_free[in_fu] && (m_count != DEPTH) && !flush;
    chk((m_count == DEPTH) ? "R10" : (flush ? "R11" : "R2"), ctx, "issue_fire",
        longint'(issue_fire), longint'(efire));
    chk("R2", ctx, "rs_we", longint'(rs_we),
        efire ? longint'(1 << in_fu) : 0);
    chk("R2", ctx, "rob_we", longint'(rob_we), longint'(efire));
    chk("R8", ctx, "rob_wr_tag", longint'(rob_wr_tag), longint'(m_tail));
    chk("R8", ctx, "rs_rob_tag", longint'(rs_rob_tag), longint'(m_tail));
    chk("R7", ctx, "rob_wr_dst", longint'({rob_wr_has_dst, rob_wr_dst}),
        longint'({in_has_dst, in_dst}));
    exp_op(in_src_a, ar, av, at, aq);
    exp_op(in_src_b, br, bv, bt, bq);
    chk(aq, ctx, "a.rdy", longint'(rs_a_rdy), longint'(ar));
    chk(aq, ctx, "a.val", longint'(rs_a_val), longint'(av));
    chk(aq, ctx, "a.tag", longint'(rs_a_tag), longint'(at));
    chk(bq, ctx, "b.rdy", longint'(rs_b_rdy), longint'(br));
    chk(bq, ctx, "b.val", longint'(rs_b_val), longint'(bv));
    chk(bq, ctx, "b.tag", longint'(rs_b_tag), longint'(bt));
    @(posedge clk);
    if (flush) begin
      clear_model();                                   // R11
    end else begin
      if (commit_valid) begin                          // R9
        for (int r = 0; r < NREG; r++)
          if (m_pend[r] && m_tag[r] == commit_tag &&
              !(efire && in_has_dst && in_dst == RW'(r)))
            m_pend[r] = 1'b0;
        m_head = (m_head + 1) % DEPTH;
        m_count--;
      end
      if (cdb_valid) begin
        rdone[cdb_tag] = 1'b1;
        rdata[cdb_tag] = cdb_data;
      end
      if (efire) begin
        if (in_has_dst) begin                          // R7, R12
          m_pend[in_dst] = 1'b1;
          m_tag[in_dst] = TAGW'(m_tail);
        end
        rdone[m_tail] = 1'b0;
        m_tail = (m_tail + 1) % DEPTH;                 // R8
        m_count++;                                     // R10
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; in_valid = 0; in_has_dst = 0; cdb_valid = 0; commit_valid = 0;
    in_fu = '0; in_op = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    rs_free = '1; cdb_tag = '0; cdb_data = '0; commit_tag = '0;
  endtask

  task automatic instr(input logic hd, input int d, input int a, input int b);
    in_valid = 1; in_has_dst = hd; in_dst = RW'(d);
    in_src_a = RW'(a); in_src_b = RW'(b); in_fu = '0; in_op = 4'h9;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int pick;
    idle();
    clear_model();
    for (int i = 0; i < DEPTH; i++) rdata[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table after reset, first tag is 0.
    instr(0, 0, 3, 7); step("R1");
    // R7: write r5 while reading r5; next reader sees the new tag.
    idle(); instr(1, 5, 5, 2); step("R7");
    idle(); instr(0, 0, 5, 5); step("R7");
    // R12: no-destination instruction leaves r6 unmapped.
    idle(); instr(0, 6, 1, 1); step("R12");
    idle(); instr(0, 0, 6, 5); step("R12");
    // R4 then R5: tag 1 (r5) broadcasts, then is read from the buffer.
    idle(); instr(0, 0, 5, 4); cdb_valid = 1; cdb_tag = 2'd1; cdb_data = 8'hC3; step("R4");
    idle(); instr(0, 0, 5, 4); step("R5");
    // R10: buffer is full now, issue must stall.
    idle(); instr(1, 9, 9, 9); step("R10");
    // R9: retire tags 0 and 1; r5 returns to the register file.
    idle(); cdb_valid = 1; cdb_tag = 2'd0; cdb_data = 8'h11; step("R9");
    idle(); commit_valid = 1; commit_tag = 2'd0; step("R9");
    idle(); commit_valid = 1; commit_tag = 2'd1; instr(0, 0, 5, 5); step("R9");
    idle(); instr(0, 0, 5, 9); step("R9");
    // R11: map r8, then flush, then r8 reads the register file again.
    idle(); instr(1, 8, 0, 0); step("R11");
    idle(); instr(1, 8, 8, 8); flush = 1; step("R11");
    idle(); instr(0, 0, 8, 8); step("R11");

    // Sweep with a bench-side pseudo-random stream.
    s = 32'h1234_5677;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      idle();
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      in_valid   = s[0] | s[1];
      in_fu      = s[2];
      in_has_dst = s[3] | s[4];
      in_dst     = s[5] ? {2'b00, s[7:6]} : s[8:5];
      in_src_a   = s[9] ? {2'b00, s[11:10]} : s[13:10];
      in_src_b   = s[14] ? {2'b00, s[16:15]} : s[18:15];
      rs_free    = {s[19] | s[20], s[21] | s[22]};
      in_op      = s[26:23];
      if (m_count > 0 && rdone[m_head] && (s[27] | s[28])) begin
        commit_valid = 1;
        commit_tag = TAGW'(m_head);
      end
      if (s[29] && m_count > 0) begin
        pick = (m_head + int'(s[31:30]) % m_count) % DEPTH;
        if (!rdone[pick]) begin
          cdb_valid = 1; cdb_tag = TAGW'(pick); cdb_data = s[15:8] ^ s[31:24];
        end
      end
      flush = (cyc % 373) == 372;
      step(flush ? "R11" : "sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule